// File: doc/BRIEF.md
# Programmable-Parity Reed-Solomon Encoder

This block is a systematic Reed-Solomon encoder over GF(256). Message bytes stream in and leave unchanged. A block ends with R check-position bytes. In each check position that is marked as an erasure, the incoming placeholder byte is replaced by a computed check byte. The parity length R is chosen at configuration time, between 2 and 20. The message length K is chosen freely, so shortened codewords are encoded directly with no zero padding.

A configuration pulse latches R and K. The block then builds the generator polynomial internally by multiplying in one root per clock. While it does so, the input is held off. Both streams use valid/ready handshakes. A byte moves when valid and ready are both high at a rising clock edge. The output stage holds its data stable until it is taken. While the output stage is occupied and the consumer is not ready, the input side drops ready, so a stall never loses encoder state.

Top module: `rs_parity_encoder`

## Requirements
- R1: Each computed check byte is a coefficient of the remainder of m(x)·x^R divided by g(x) = (x+α^120)(x+α^121)…(x+α^(119+R)). Here α is a root of x^8+x^7+x^2+x+1 (reduction constant 0x187). The first message byte received is the highest-degree coefficient of m(x), and check bytes are emitted highest-degree first.
- R2: A requested parity length below 2 is treated as 2, and one above 20 is treated as 20.
- R3: Any message length K from 1 to 255−R is encoded from exactly K message bytes, with no leading zero bytes supplied.
- R4: A block is K message positions followed by R check positions. Message bytes leave unchanged, with out_gen = 0.
- R5: In a check position with in_erase = 1, the output is the next computed check byte, with out_gen = 1. With in_erase = 0, the input byte passes unchanged, with out_gen = 0, and the parity sequence still advances. in_erase has no effect in message positions.
- R6: After reset, out_valid and in_ready are 0 until a configuration completes. After cfg_load, in_ready stays low for exactly R_eff cycles (the clamped R), then rises.
- R7: A byte accepted at an edge appears on the output after that same edge. With out_ready held high, one byte is accepted every clock.
- R8: While out_valid = 1 and out_ready = 0, out_data and out_gen hold stable and in_ready is 0. No byte is lost or duplicated.
- R9: Consecutive blocks are encoded independently, with no reconfiguration between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | One-cycle pulse that latches cfg_r and cfg_k and starts the generator build |
| cfg_r | input | 5 | Requested parity length |
| cfg_k | input | 8 | Message length K |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Encoder can accept a byte |
| in_data | input | 8 | Input byte |
| in_erase | input | 1 | Marks a check-position byte as a placeholder to replace |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Output byte |
| out_gen | output | 1 | Output byte is a computed check byte |

## Verification
The output register loads at the edge that accepts a byte, so the bench drives inputs at the falling edge. It samples one time unit later and expects the byte one half-period after its accepting edge. For the generator build, the bench counts the falling-edge samples that show in_ready low after the pulse has been taken. It expects exactly R_eff of them. Under random backpressure, the bench records any held output and compares it on the next sample. Expected codewords come from long division by a generator the bench builds itself.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  localparam logic [SYM_W:0] FIELD_POLY = 9'h187;

  typedef logic [SYM_W-1:0] sym_t;

  // multiply by alpha: shift left, reduce when the top bit falls out
  function automatic sym_t gf_xtime(input sym_t a);
    sym_t s;
    s = {a[SYM_W-2:0], 1'b0};
    if (a[SYM_W-1]) s = s ^ FIELD_POLY[SYM_W-1:0];
    return s;
  endfunction

  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t acc;
    acc = '0;
    for (int i = SYM_W - 1; i >= 0; i--) begin
      acc = gf_xtime(acc);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic sym_t gf_alpha_pow(input int n);
    sym_t x;
    x = sym_t'(1);
    for (int i = 0; i < n; i++) x = gf_xtime(x);
    return x;
  endfunction
endpackage

// File: rtl/rs_genpoly_builder.sv
module rs_genpoly_builder import rs_enc_pkg::*; #(
  parameter int MAX_R      = 20,
  parameter int FIRST_ROOT = 120,
  parameter int RW         = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [RW-1:0]            r_len,
  output logic                     busy,
  output logic [MAX_R-1:0][SYM_W-1:0] coef
);
  localparam sym_t ROOT0 = gf_alpha_pow(FIRST_ROOT);
  localparam int   NC    = MAX_R + 1;

  logic [NC-1:0][SYM_W-1:0] poly;
  logic [NC-1:0][SYM_W-1:0] poly_nxt;
  sym_t                     root;
  logic [RW-1:0]            step;

  // poly[j] is the coefficient of x^j; one factor (x + root) per clock
  always_comb begin
    poly_nxt[0] = gf_mul(root, poly[0]);
    for (int j = 1; j < NC; j++) begin
      poly_nxt[j] = poly[j-1] ^ gf_mul(root, poly[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      root <= ROOT0;
      poly <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      step    <= '0;
      root    <= ROOT0;
      poly    <= '0;
      poly[0] <= sym_t'(1);
    end else if (busy) begin
      poly <= poly_nxt;
      root <= gf_xtime(root);
      step <= step + RW'(1);
      if (step == r_len - RW'(1)) busy <= 1'b0;
    end
  end

  // monic leading term dropped; unused upper taps forced to zero
  always_comb begin
    for (int i = 0; i < MAX_R; i++) begin
      coef[i] = (i < int'(r_len)) ? poly[i] : '0;
    end
  end
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr import rs_enc_pkg::*; #(
  parameter int MAX_R = 20,
  parameter int RW    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        shift_en,
  input  logic                        msg_phase,
  input  logic [SYM_W-1:0]            din,
  input  logic [RW-1:0]               r_len,
  input  logic [MAX_R-1:0][SYM_W-1:0] coef,
  output logic [SYM_W-1:0]            top_sym
);
  logic [MAX_R-1:0][SYM_W-1:0] st;
  logic [MAX_R-1:0][SYM_W-1:0] st_nxt;
  sym_t                        fb;

  always_comb begin
    top_sym = '0;
    for (int i = 0; i < MAX_R; i++) begin
      if (int'(r_len) == i + 1) top_sym = st[i];
    end
  end

  // in check positions the feedback is zero: stages shift toward the top
  assign fb = msg_phase ? (din ^ top_sym) : '0;

  always_comb begin
    st_nxt[0] = gf_mul(coef[0], fb);
    for (int i = 1; i < MAX_R; i++) begin
      st_nxt[i] = st[i-1] ^ gf_mul(coef[i], fb);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) st <= '0;
    else if (shift_en)   st <= st_nxt;
  end
endmodule

// File: rtl/rs_block_counter.sv
module rs_block_counter #(
  parameter int KW = 8,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  input  logic [KW-1:0] k_len,
  input  logic [RW-1:0] r_len,
  output logic          in_check,
  output logic          last
);
  localparam int CW = KW + 1;

  logic [CW-1:0] pos;
  logic [CW-1:0] end_pos;

  assign end_pos  = CW'(k_len) + CW'(r_len) - CW'(1);
  assign in_check = pos >= CW'(k_len);
  assign last     = pos == end_pos;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) pos <= '0;
    else if (advance)    pos <= last ? '0 : pos + CW'(1);
  end
endmodule

// File: rtl/rs_parity_encoder.sv
module rs_parity_encoder import rs_enc_pkg::*; #(
  parameter int MAX_R      = 20,
  parameter int MIN_R      = 2,
  parameter int FIRST_ROOT = 120,
  parameter int RW         = $clog2(MAX_R + 1),
  parameter int KW         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [RW-1:0]    cfg_r,
  input  logic [KW-1:0]    cfg_k,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_erase,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_data,
  output logic             out_gen
);
  logic [RW-1:0]               r_sel;
  logic [RW-1:0]               r_reg;
  logic [KW-1:0]               k_reg;
  logic                        configured;
  logic                        build_busy;
  logic [MAX_R-1:0][SYM_W-1:0] coef;
  logic                        in_check;
  logic                        last;
  logic                        fire;
  sym_t                        top_sym;

  always_comb begin
    if (int'(cfg_r) < MIN_R)      r_sel = RW'(MIN_R);
    else if (int'(cfg_r) > MAX_R) r_sel = RW'(MAX_R);
    else                          r_sel = cfg_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_reg      <= RW'(MIN_R);
      k_reg      <= KW'(1);
      configured <= 1'b0;
    end else if (cfg_load) begin
      r_reg      <= r_sel;
      k_reg      <= cfg_k;
      configured <= 1'b1;
    end
  end

  assign in_ready = configured && !build_busy && !cfg_load && (!out_valid || out_ready);
  assign fire     = in_valid && in_ready;

  rs_genpoly_builder #(.MAX_R(MAX_R), .FIRST_ROOT(FIRST_ROOT), .RW(RW)) u_builder (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cfg_load),
    .r_len (r_reg),
    .busy  (build_busy),
    .coef  (coef)
  );

  rs_block_counter #(.KW(KW), .RW(RW)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cfg_load),
    .advance  (fire),
    .k_len    (k_reg),
    .r_len    (r_reg),
    .in_check (in_check),
    .last     (last)
  );

  rs_parity_lfsr #(.MAX_R(MAX_R), .RW(RW)) u_lfsr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cfg_load),
    .shift_en  (fire),
    .msg_phase (!in_check),
    .din       (in_data),
    .r_len     (r_reg),
    .coef      (coef),
    .top_sym   (top_sym)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_gen   <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      if (in_check && in_erase) begin
        out_data <= top_sym;
        out_gen  <= 1'b1;
      end else begin
        out_data <= in_data;
        out_gen  <= 1'b0;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rs_enc_checker.sv
module rs_enc_checker #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [SW-1:0] out_data,
  input logic          out_gen,
  input logic          build_busy,
  input logic          in_check
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_gen))); // R8

  AST_BP_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_BUILD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    build_busy |-> !in_ready); // R6

  AST_CFG_STARTS_BUILD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> build_busy); // R6

  AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R7

  AST_MSG_NOT_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_check) |=> !out_gen); // R4
endmodule

bind rs_parity_encoder rs_enc_checker #(.SW(rs_enc_pkg::SYM_W)) u_rs_enc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_gen    (out_gen),
  .build_busy (build_busy),
  .in_check   (in_check)
);

// File: tb/test_rs_parity_encoder.sv
module test_rs_parity_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_load = 1'b0;
  logic [4:0] cfg_r = '0;
  logic [7:0] cfg_k = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_erase = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_gen;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] b_msg [256];
  bit         b_era [256];
  logic [7:0] exp_d [256];
  bit         exp_g [256];
  logic [7:0] gp    [21];
  logic [7:0] work  [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_parity_encoder i_rs_parity_encoder (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_r(cfg_r), .cfg_k(cfg_k),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_erase(in_erase),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_gen(out_gen)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] res, aa, bb;
    logic       carry;
    res = 0; aa = a; bb = b;
    for (int i = 0; i < 8; i++) begin
      if (bb[0]) res = res ^ aa;
      carry = aa[7];
      aa = {aa[6:0], 1'b0};
      if (carry) aa = aa ^ 8'h87;
      bb = bb >> 1;
    end
    return res;
  endfunction

  function automatic logic [7:0] b_alpha(input int n);
    logic [7:0] x;
    x = 8'd1;
    for (int i = 0; i < n; i++) x = b_mul(x, 8'd2);
    return x;
  endfunction

  // generator in descending order: gp[0] = 1 is the x^r coefficient
  task automatic build_expected(input int k, input int r);
    logic [7:0] a, c;
    for (int j = 0; j < 21; j++) gp[j] = 0;
    gp[0] = 8'd1;
    for (int i = 0; i < r; i++) begin
      a = b_alpha(120 + i);
      for (int j = i + 1; j >= 1; j--) gp[j] = gp[j] ^ b_mul(a, gp[j-1]);
    end
    for (int p = 0; p < k + r; p++) work[p] = (p < k) ? b_msg[p] : 8'd0;
    for (int i = 0; i < k; i++) begin
      c = work[i];
      for (int j = 1; j <= r; j++) work[i+j] = work[i+j] ^ b_mul(c, gp[j]);
    end
    for (int p = 0; p < k + r; p++) begin
      if (p < k) begin
        exp_d[p] = b_msg[p]; exp_g[p] = 1'b0;
      end else if (b_era[p]) begin
        exp_d[p] = work[p]; exp_g[p] = 1'b1;
      end else begin
        exp_d[p] = b_msg[p]; exp_g[p] = 1'b0;
      end
    end
  endtask

  task automatic configure(input int rin, input int k, input int exp_r, input string tag);
    int cnt;
    @(negedge clk);
    in_valid = 0; out_ready = 1;
    cfg_r = 5'(rin); cfg_k = 8'(k); cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
    cnt = 0;
    #1;
    while (!in_ready && cnt < 100) begin
      cnt++;
      @(negedge clk);
      #1;
    end
    chk(cnt == exp_r, tag, cnt, exp_r);
  endtask

  task automatic run_block(input int k, input int r, input int vpct, input int rpct,
                           input bit all_erase, input string label, output int in_cycles);
    int n, in_idx, out_idx, guard;
    bit prev_acc, held, hg;
    logic [7:0] hd;
    n = k + r;
    for (int p = 0; p < n; p++) begin
      b_msg[p] = 8'($urandom);
      b_era[p] = (p >= k && all_erase) ? 1'b1 : 1'($urandom);
    end
    build_expected(k, r);
    in_idx = 0; out_idx = 0; guard = 0; in_cycles = 0;
    prev_acc = 0; held = 0; hd = 0; hg = 0;
    while (out_idx < n && guard < 5000) begin
      @(negedge clk);
      guard++;
      in_valid  = (in_idx < n) && (($urandom % 100) < vpct);
      in_data   = (in_idx < n) ? b_msg[in_idx] : 8'd0;
      in_erase  = (in_idx < n) ? b_era[in_idx] : 1'b0;
      out_ready = (($urandom % 100) < rpct);
      #1;
      if (prev_acc) chk(out_valid == 1'b1, {"R7 output after accept ", label}, out_valid, 1);
      if (held) chk(out_valid && out_data == hd && out_gen == hg,
                    {"R8 held output ", label}, out_data, hd);
      if (out_valid && !out_ready) chk(!in_ready, {"R8 ready low while stalled ", label}, in_ready, 0);
      if (in_idx < n) in_cycles++;
      prev_acc = in_valid && in_ready;
      if (prev_acc) in_idx++;
      held = out_valid && !out_ready;
      hd = out_data; hg = out_gen;
      if (out_valid && out_ready) begin
        if (out_idx < k)
          chk(out_data == exp_d[out_idx], {"R4 message byte ", label}, out_data, exp_d[out_idx]);
        else if (b_era[out_idx])
          chk(out_data == exp_d[out_idx], {"R1 check byte ", label}, out_data, exp_d[out_idx]);
        else
          chk(out_data == exp_d[out_idx], {"R5 unmarked check position ", label}, out_data, exp_d[out_idx]);
        chk(out_gen == exp_g[out_idx], {"R5 generated flag ", label}, out_gen, exp_g[out_idx]);
        out_idx++;
      end
    end
    chk(out_idx == n, {"R8 byte count ", label}, out_idx, n);
    @(negedge clk);
    in_valid = 0; out_ready = 1;
  endtask

  initial begin
    int ic, r, k;
    void'($urandom(32'd4242));
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(in_ready == 1'b0, "R6 in_ready after reset", in_ready, 0);
    chk(out_valid == 1'b0, "R6 out_valid after reset", out_valid, 0);
    @(negedge clk);
    in_valid = 1; in_data = 8'h5a; out_ready = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R6 nothing accepted before configuration", out_valid, 0);
    in_valid = 0;

    configure(4, 10, 4, "R6 build time R=4");
    run_block(10, 4, 100, 100, 1'b1, "full rate", ic);
    chk(ic == 14, "R7 one byte per clock", ic, 14);
    run_block(10, 4, 60, 50, 1'b1, "R9 second block", ic);

    configure(16, 239, 16, "R6 build time R=16");
    run_block(239, 16, 70, 60, 1'b0, "N=255 mixed erase", ic);

    configure(0, 1, 2, "R2 clamp low to 2");
    run_block(1, 2, 80, 70, 1'b1, "R3 shortest block", ic);
    run_block(1, 2, 80, 70, 1'b1, "R3 shortest block again", ic);

    configure(31, 5, 20, "R2 clamp high to 20");
    run_block(5, 20, 90, 40, 1'b1, "R3 short with R=20", ic);

    configure(20, 235, 20, "R6 build time R=20");
    run_block(235, 20, 100, 100, 1'b1, "max block full rate", ic);
    chk(ic == 255, "R7 one byte per clock at N=255", ic, 255);

    for (int t = 0; t < 8; t++) begin
      r = 2 + int'($urandom % 19);
      k = 1 + int'($urandom % (255 - r));
      configure(r, k, r, "R6 build time random");
      run_block(k, r, 75, 65, 1'b0, "R9 random block a", ic);
      run_block(k, r, 75, 65, 1'b1, "R9 random block b", ic);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule